// File: doc/BRIEF.md
# Integer Adder-Subtractor with Condition Flags

This block is a parameterised-width two's-complement arithmetic unit that adds or subtracts two operand words and reports four condition flags: negative, zero, carry and signed overflow. A single adder serves every operation. A subtract feeds the bit-inverted second operand into the adder with a carry-in, so the sum bits are the same whether the operands are read as signed or unsigned. Only the flags tell those two readings apart.

The result appears combinationally in the same cycle as the operands. The flags are captured in a register on each cycle where the operation-valid input is high. Because the stored carry becomes the carry-in of the chained operations, a wide sum or difference can be built one word at a time. The carry polarity after a subtract is chosen by an input: either the raw adder carry-out, or its inverse read as a borrow.

Top module: `addsub_flags`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four flags are cleared to 0 at that edge.
- R2: With `op_sel` = 2'b00 (plain add), `result` equals `opa + opb` modulo 2^WIDTH, and the stored carry becomes the carry out of the top bit.
- R3: With `op_sel` = 2'b10 (plain subtract), `result` equals `opa - opb` modulo 2^WIDTH, formed as `opa + ~opb + 1`. With `borrow_mode` = 0 the stored carry is the raw carry-out, which is 1 when `opa >= opb` unsigned.
- R4: With `borrow_mode` = 1, the carry stored after a subtract (`op_sel` 2'b10 or 2'b11) is the inverse of the adder carry-out, which is 1 when a borrow occurred. After an add (`op_sel` 2'b00 or 2'b01) the carry is never inverted.
- R5: With `op_sel` = 2'b01 (add with carry), the adder carry-in is the stored carry flag. A plain add of low words followed by this operation on high words therefore yields a double-width sum.
- R6: With `op_sel` = 2'b11 (subtract with borrow), the adder carry-in is the stored carry when `borrow_mode` = 0 and its inverse when `borrow_mode` = 1. This chains a multi-word subtract.
- R7: After an update, `flag_n` equals the top bit of the result and `flag_z` is 1 exactly when every result bit is 0.
- R8: After an update, `flag_v` is 1 exactly when the carry into the top bit differs from the carry out of it (signed overflow).
- R9: On a clock edge with `op_valid` low and `rst` low, all flags keep their values. `result` still follows the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_valid | input | 1 | Capture the flags of this cycle's operation |
| op_sel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| borrow_mode | input | 1 | 1 stores an inverted carry (borrow) after a subtract |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| result | output | WIDTH | Combinational sum or difference |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry or borrow flag |
| flag_v | output | 1 | Registered signed-overflow flag |

## Verification
Two functions of the block meet in the same cycle during a chained operation. Add-with-carry or subtract-with-borrow reads the stored carry as its carry-in, and the same clock edge overwrites that carry with the new outcome. Under the borrow convention, the inversion applies both where the carry is consumed and where it is stored.

The bench provokes this with back-to-back chained operations whose carry-in and carry-out differ, in both polarities. It checks the combinational result before the edge and the new flags after it. Double-word add and subtract sequences then confirm that the carry handed between words is the one from the previous cycle.

// File: rtl/addsub_flags_pkg.sv
package addsub_flags_pkg;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_ADC = 2'b01,
        OP_SUB = 2'b10,
        OP_SBB = 2'b11
    } arith_op_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } cond_flags_t;

    localparam cond_flags_t FLAGS_CLEAR = '{neg: 1'b0, zero: 1'b0, carry: 1'b0, ovf: 1'b0};

    function automatic logic op_is_sub(input arith_op_e op);
        return (op == OP_SUB) || (op == OP_SBB);
    endfunction

    function automatic logic op_is_chained(input arith_op_e op);
        return (op == OP_ADC) || (op == OP_SBB);
    endfunction

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
    import addsub_flags_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  arith_op_e          op,
    input  logic               borrow_mode,
    input  logic               stored_carry,
    input  logic [WIDTH-1:0]   opb_in,
    output logic [WIDTH-1:0]   opb_eff,
    output logic               carry_in
);

    logic sub_op;
    logic chained;
    logic chained_cin;

    assign sub_op  = op_is_sub(op);
    assign chained = op_is_chained(op);

    // A chained subtract under the borrow convention consumes the stored borrow inverted.
    assign chained_cin = (sub_op && borrow_mode) ? ~stored_carry : stored_carry;

    always_comb begin
        opb_eff = sub_op ? ~opb_in : opb_in;
        if (chained) begin
            carry_in = chained_cin;
        end else begin
            carry_in = sub_op;
        end
    end

endmodule

// File: rtl/addsub_core.sv
module addsub_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry_msb_in,
    output logic             carry_out
);

    localparam int LOW_W = WIDTH - 1;

    logic [LOW_W:0] low_sum;
    logic [1:0]     top_sum;

    // Split the adder so the carry entering the top bit is visible for overflow detection.
    assign low_sum      = {1'b0, a[LOW_W-1:0]} + {1'b0, b[LOW_W-1:0]} + {{LOW_W{1'b0}}, cin};
    assign carry_msb_in = low_sum[LOW_W];
    assign top_sum      = {1'b0, a[WIDTH-1]} + {1'b0, b[WIDTH-1]} + {1'b0, carry_msb_in};
    assign carry_out    = top_sum[1];
    assign sum          = {top_sum[0], low_sum[LOW_W-1:0]};

endmodule

// File: rtl/addsub_flag_reg.sv
module addsub_flag_reg
    import addsub_flags_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             update,
    input  arith_op_e        op,
    input  logic             borrow_mode,
    input  logic [WIDTH-1:0] sum,
    input  logic             carry_msb_in,
    input  logic             carry_out,
    output cond_flags_t      flags_q
);

    cond_flags_t flags_d;

    always_comb begin
        flags_d.neg   = sum[WIDTH-1];
        flags_d.zero  = (sum == '0);
        flags_d.carry = (op_is_sub(op) && borrow_mode) ? ~carry_out : carry_out;
        flags_d.ovf   = carry_msb_in ^ carry_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= FLAGS_CLEAR;
        end else if (update) begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
    import addsub_flags_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic             borrow_mode,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    arith_op_e        op;
    logic [WIDTH-1:0] opb_eff;
    logic             cin;
    logic             c_msb;
    logic             c_out;
    cond_flags_t      flags;

    assign op = arith_op_e'(op_sel);

    generate
        if (WIDTH < 2) begin : g_bad_width
            initial $error("addsub_flags: WIDTH must be at least 2");
        end
    endgenerate

    addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .op           (op),
        .borrow_mode  (borrow_mode),
        .stored_carry (flags.carry),
        .opb_in       (opb),
        .opb_eff      (opb_eff),
        .carry_in     (cin)
    );

    addsub_core #(.WIDTH(WIDTH)) u_core (
        .a            (opa),
        .b            (opb_eff),
        .cin          (cin),
        .sum          (result),
        .carry_msb_in (c_msb),
        .carry_out    (c_out)
    );

    addsub_flag_reg #(.WIDTH(WIDTH)) u_flags (
        .clk          (clk),
        .rst          (rst),
        .update       (op_valid),
        .op           (op),
        .borrow_mode  (borrow_mode),
        .sum          (result),
        .carry_msb_in (c_msb),
        .carry_out    (c_out),
        .flags_q      (flags)
    );

    assign flag_n = flags.neg;
    assign flag_z = flags.zero;
    assign flag_c = flags.carry;
    assign flag_v = flags.ovf;

endmodule

// File: rtl/addsub_flags_chk.sv
module addsub_flags_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             op_valid,
    input logic [1:0]       op_sel,
    input logic             borrow_mode,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v
);

    logic [WIDTH:0] wide_add;
    assign wide_add = {1'b0, opa} + {1'b0, opb};

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> {flag_n, flag_z, flag_c, flag_v} == 4'b0000);

    // R2
    a_r2_add_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b00) |=> flag_c == $past(wide_add[WIDTH]));

    // R3
    a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 2'b10) |-> result == WIDTH'(opa - opb));

    // R3
    a_r3_raw_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10 && !borrow_mode) |=> flag_c == $past(opa >= opb));

    // R4
    a_r4_borrow_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b10 && borrow_mode) |=> flag_c == $past(opa < opb));

    // R7
    a_r7_neg_zero: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flag_n == $past(result[WIDTH-1])) && (flag_z == $past(result == '0)));

    // R8
    a_r8_add_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == 2'b00) |=>
            flag_v == $past((opa[WIDTH-1] == opb[WIDTH-1]) && (result[WIDTH-1] != opa[WIDTH-1])));

    // R9
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable({flag_n, flag_z, flag_c, flag_v}));

endmodule

bind addsub_flags addsub_flags_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .borrow_mode (borrow_mode),
    .opa         (opa),
    .opb         (opb),
    .result      (result),
    .flag_n      (flag_n),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .flag_v      (flag_v)
);

// File: tb/test_addsub_flags.sv
module test_addsub_flags;

    localparam int W = 8;
    localparam int NVEC = 14;

    // {op, borrow_mode, a, b, expected result, expected nzcv}
    typedef struct packed {
        logic [1:0]   op;
        logic         bm;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] res;
        logic [3:0]   nzcv;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 4'b1001},
        '{2'b00, 1'b0, 8'hFF, 8'h01, 8'h00, 4'b0110},
        '{2'b01, 1'b0, 8'h10, 8'h20, 8'h31, 4'b0000},
        '{2'b10, 1'b0, 8'h0D, 8'h0C, 8'h01, 4'b0010},
        '{2'b10, 1'b0, 8'h0C, 8'h0C, 8'h00, 4'b0110},
        '{2'b10, 1'b0, 8'h0B, 8'h0C, 8'hFF, 4'b1000},
        '{2'b10, 1'b1, 8'h0B, 8'h0C, 8'hFF, 4'b1010},
        '{2'b11, 1'b1, 8'h05, 8'h03, 8'h01, 4'b0000},
        '{2'b11, 1'b1, 8'h05, 8'h03, 8'h02, 4'b0000},
        '{2'b00, 1'b1, 8'h80, 8'h80, 8'h00, 4'b0111},
        '{2'b11, 1'b0, 8'h80, 8'h01, 8'h7F, 4'b0011},
        '{2'b11, 1'b0, 8'h00, 8'h01, 8'hFF, 4'b1000},
        '{2'b11, 1'b0, 8'h05, 8'h03, 8'h01, 4'b0010},
        '{2'b01, 1'b0, 8'hFF, 8'h00, 8'h00, 4'b0110}
    };

    localparam string VREQ [NVEC] = '{
        "R8", "R2", "R5", "R3", "R7", "R3", "R4", "R6",
        "R6", "R4", "R6", "R6", "R6", "R5"
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         op_valid = 1'b0;
    logic [1:0]   op_sel = 2'b00;
    logic         borrow_mode = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [W-1:0] result;
    logic         flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    addsub_flags #(.WIDTH(W)) i_addsub_flags (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_sel      (op_sel),
        .borrow_mode (borrow_mode),
        .opa         (opa),
        .opb         (opb),
        .result      (result),
        .flag_n      (flag_n),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .flag_v      (flag_v)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive at the falling edge, check the result before the rising edge, flags after it.
    task automatic apply(input string req, input logic v, input logic [1:0] op, input logic bm,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] exp_res, input logic [3:0] exp_nzcv);
        @(negedge clk);
        op_valid = v; op_sel = op; borrow_mode = bm; opa = a; opb = b;
        #1;
        chk(req, "result", 32'(result), 32'(exp_res));
        @(posedge clk);
        #1;
        chk(req, "nzcv", 32'({flag_n, flag_z, flag_c, flag_v}), 32'(exp_nzcv));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "nzcv after reset", 32'({flag_n, flag_z, flag_c, flag_v}), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VREQ[i], 1'b1, VECS[i].op, VECS[i].bm, VECS[i].a, VECS[i].b,
                  VECS[i].res, VECS[i].nzcv);
        end

        // R9: idle cycle; result follows operands, flags keep 0110
        apply("R9", 1'b0, 2'b00, 1'b0, 8'h7F, 8'h01, 8'h80, 4'b0110);
        apply("R9", 1'b0, 2'b10, 1'b1, 8'h00, 8'h01, 8'hFF, 4'b0110);

        // R1: reset mid-run clears the flags
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "nzcv after mid reset", 32'({flag_n, flag_z, flag_c, flag_v}), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R5: 16-bit add 0x12F0 + 0x0135 = 0x1425 in two words
        apply("R5", 1'b1, 2'b00, 1'b0, 8'hF0, 8'h35, 8'h25, 4'b0010);
        apply("R5", 1'b1, 2'b01, 1'b0, 8'h12, 8'h01, 8'h14, 4'b0000);

        // R6/R4: 16-bit subtract 0x1400 - 0x0001 = 0x13FF with borrow convention
        apply("R4", 1'b1, 2'b10, 1'b1, 8'h00, 8'h01, 8'hFF, 4'b1010);
        apply("R6", 1'b1, 2'b11, 1'b1, 8'h14, 8'h00, 8'h13, 4'b0000);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule